// File: doc/BRIEF.md
# Timed Latching Threshold Alarm Engine

This block watches a single sampled current magnitude against a shared set of programmable limits and presents the outcome as a 16-bit alarm status word. Four levels (high-high, high, low, low-low) are *latching*. A level's bit sets only after its condition has held over a programmable number of tick strobes. Once set, the bit stays set until software clears it or the level's limit is reprogrammed. Two further *non-latching* alarms (high and low) react on the first qualifying tick and release through a hysteresis band given as a percentage of their setpoint.

A separate on/off detector follows the low-low limit. It first declares an "on" state once the input has stayed above low-low long enough. It then latches an off-state bit if the input stays at or below low-low for a second programmable time while "on" is declared.

The surrounding system supplies the magnitude, a tick strobe that paces every evaluation, the limits, the delays, the hysteresis percentage and a status write port. All evaluations happen on clock edges where `tick` is high. The status output reflects the result on the following cycle.

Top module: `thr_alarm_eng`

## Requirements
- R1: After reset every status bit reads 0, all delay counters are empty and the on state is not declared.
- R2: Latching level bits sit at bit 0 (high-high), bit 1 (high), bit 2 (low) and bit 3 (low-low). The high levels qualify on `sample >= limit` and the low levels on `sample <= limit`. With delay D, the bit sets on the (D+1)-th consecutive tick that qualifies. A tick that does not qualify restarts the count, so D = 0 sets on the first qualifying tick.
- R3: A set latching bit (bits 0 to 4) stays set after its condition goes away.
- R4: A status write clears each latching bit 0 to 4 whose write-data bit is 0 and leaves it unchanged where the data bit is 1. Writes never change bits 8 and 9.
- R5: A change in a level's limit value clears that level's latching bit. A change in the low-low limit also clears bit 4.
- R6: When a latching bit's set condition and a clear (write or limit change) fall in the same cycle, the bit ends up set.
- R7: The non-latching high bit (bit 8) sets on the first tick with `sample >= nl_hi_thr`. The non-latching low bit (bit 9) sets on the first tick with `sample <= nl_lo_thr`. There is no delay for either.
- R8: With h = min(hyst_pct, 100), bit 8 clears on a tick with `sample < nl_hi_thr*(100-h)/100`. Bit 9 clears on a tick with `sample > nl_lo_thr*(100+h)/100`. Both divisions are integer (truncating). Between the set and release points the bit holds. Latching levels use no hysteresis.
- R9: A limit of 0 disables its alarm, so its bit never sets. A zero low-low limit also disables the on/off detector.
- R10: The on state is declared on the (dly_on+1)-th consecutive tick with `sample > ll_thr`. While on, the (dly_off+1)-th consecutive tick with `sample <= ll_thr` sets bit 4 and withdraws the on state.
- R11: Bits 5 to 7 and 10 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Evaluation strobe; counters and alarms advance only when high |
| sample | input | W | Measured magnitude |
| hh_thr | input | W | High-high latching limit (0 disables) |
| hi_thr | input | W | High latching limit (0 disables) |
| lo_thr | input | W | Low latching limit (0 disables) |
| ll_thr | input | W | Low-low latching limit and on/off reference (0 disables) |
| nl_hi_thr | input | W | Non-latching high limit (0 disables) |
| nl_lo_thr | input | W | Non-latching low limit (0 disables) |
| hyst_pct | input | 7 | Hysteresis percent for non-latching alarms, values above 100 act as 100 |
| hh_dly | input | DW | High-high qualifying delay in ticks |
| hi_dly | input | DW | High qualifying delay in ticks |
| lo_dly | input | DW | Low qualifying delay in ticks |
| ll_dly | input | DW | Low-low qualifying delay in ticks |
| on_dly | input | DW | Ticks above low-low needed to declare on |
| off_dly | input | DW | Ticks at or below low-low needed to latch off |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data; 0 in bits 0 to 4 clears those bits |
| status | output | 16 | Alarm status word |

## Verification
The bench builds the engine with W = 12 and DW = 4. With a 4-bit delay, every qualifying window (at most 16 ticks) can run to completion many times within a few thousand random cycles, including saturation at the largest delay. A 12-bit magnitude keeps limits, hysteresis products and release points small enough that random samples drawn around each limit regularly land on the exact set and release boundaries. Random limit rewrites and status writes then collide with pending sets often enough to exercise the set-over-clear rule.

// File: rtl/thr_alarm_pkg.sv
package thr_alarm_pkg;
  localparam int ST_W  = 16;
  localparam int NLVL  = 4;
  localparam int NLAT  = 5;
  localparam int B_OFF = 4;
  localparam int B_NH  = 8;
  localparam int B_NL  = 9;
  localparam int PCT_W = 7;
  localparam logic [PCT_W-1:0] PCT_MAX = 7'd100;
endpackage

// File: rtl/thr_dly_qual.sv
module thr_dly_qual #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cond,
  input  logic [DW-1:0] dly,
  output logic          hit
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = tick;
    cnt_d  = cnt_q;
    if (!cond)            cnt_d = '0;
    else if (cnt_q < dly) cnt_d = cnt_q + 1'b1;
  end

  assign hit = tick & cond & (cnt_q >= dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/thr_nl_alarm.sv
module thr_nl_alarm
  import thr_alarm_pkg::*;
#(
  parameter int W    = 12,
  parameter bit HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [W-1:0]     sample,
  input  logic [W-1:0]     thr,
  input  logic [PCT_W-1:0] hyst,
  output logic             flag
);
  localparam int PW = W + 8;

  logic [PCT_W-1:0] h_c;
  logic [7:0]       fac;
  logic [PW-1:0]    rel;
  logic             trip, release_ok, en, flag_d;

  assign h_c = (hyst > PCT_MAX) ? PCT_MAX : hyst;
  assign en  = (thr != '0);

  generate
    if (HIGH) begin : g_high
      assign fac        = 8'd100 - {1'b0, h_c};
      assign trip       = (sample >= thr);
      assign release_ok = (PW'(sample) < rel);
    end else begin : g_low
      assign fac        = 8'd100 + {1'b0, h_c};
      assign trip       = (sample <= thr);
      assign release_ok = (PW'(sample) > rel);
    end
  endgenerate

  assign rel = (PW'(thr) * PW'(fac)) / PW'(100);

  always_comb begin
    flag_d = flag;
    if (!en)                      flag_d = 1'b0;
    else if (tick) begin
      if (!flag && trip)          flag_d = 1'b1;
      else if (flag && release_ok) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/thr_onoff_det.sv
module thr_onoff_det #(
  parameter int W  = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [W-1:0]  sample,
  input  logic [W-1:0]  ll_thr,
  input  logic [DW-1:0] on_dly,
  input  logic [DW-1:0] off_dly,
  output logic          off_hit
);
  logic on_q, on_d, en, above, on_cond, off_cond, on_hit;

  assign en       = (ll_thr != '0);
  assign above    = (sample > ll_thr);
  assign on_cond  = en & ~on_q & above;
  assign off_cond = en & on_q & ~above;

  thr_dly_qual #(.DW(DW)) u_on (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(on_cond), .dly(on_dly), .hit(on_hit)
  );
  thr_dly_qual #(.DW(DW)) u_off (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(off_cond), .dly(off_dly), .hit(off_hit)
  );

  always_comb begin
    on_d = on_q;
    if (!en)         on_d = 1'b0;
    else if (on_hit) on_d = 1'b1;
    else if (off_hit) on_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end
endmodule

// File: rtl/thr_alarm_eng.sv
module thr_alarm_eng
  import thr_alarm_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [W-1:0]     sample,
  input  logic [W-1:0]     hh_thr,
  input  logic [W-1:0]     hi_thr,
  input  logic [W-1:0]     lo_thr,
  input  logic [W-1:0]     ll_thr,
  input  logic [W-1:0]     nl_hi_thr,
  input  logic [W-1:0]     nl_lo_thr,
  input  logic [PCT_W-1:0] hyst_pct,
  input  logic [DW-1:0]    hh_dly,
  input  logic [DW-1:0]    hi_dly,
  input  logic [DW-1:0]    lo_dly,
  input  logic [DW-1:0]    ll_dly,
  input  logic [DW-1:0]    on_dly,
  input  logic [DW-1:0]    off_dly,
  input  logic             stat_wr,
  input  logic [ST_W-1:0]  stat_wdata,
  output logic [ST_W-1:0]  status
);
  logic [NLVL-1:0][W-1:0]  lthr, lthr_q;
  logic [NLVL-1:0][DW-1:0] ldly;
  logic [NLVL-1:0]         lcond, lhit, lchg;
  logic [NLAT-1:0]         lat_q, lat_d, lat_set, lat_clr;
  logic                    off_hit, nh_flag, nl_flag;

  assign lthr = {ll_thr, lo_thr, hi_thr, hh_thr};
  assign ldly = {ll_dly, lo_dly, hi_dly, hh_dly};

  genvar k;
  generate
    for (k = 0; k < NLVL; k++) begin : g_lvl
      if (k < 2) begin : g_hi
        assign lcond[k] = (lthr[k] != '0) && (sample >= lthr[k]);
      end else begin : g_lo
        assign lcond[k] = (lthr[k] != '0) && (sample <= lthr[k]);
      end
      assign lchg[k] = (lthr[k] != lthr_q[k]);
      thr_dly_qual #(.DW(DW)) u_q (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(lcond[k]), .dly(ldly[k]), .hit(lhit[k])
      );
    end
  endgenerate

  thr_onoff_det #(.W(W), .DW(DW)) u_onoff (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .ll_thr(ll_thr),
    .on_dly(on_dly), .off_dly(off_dly), .off_hit(off_hit)
  );

  thr_nl_alarm #(.W(W), .HIGH(1'b1)) u_nh (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .thr(nl_hi_thr),
    .hyst(hyst_pct), .flag(nh_flag)
  );
  thr_nl_alarm #(.W(W), .HIGH(1'b0)) u_nl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .thr(nl_lo_thr),
    .hyst(hyst_pct), .flag(nl_flag)
  );

  always_comb begin
    lat_set = {off_hit, lhit};
    lat_clr = {lchg[NLVL-1], lchg};
    if (stat_wr) lat_clr = lat_clr | ~stat_wdata[NLAT-1:0];
    lat_d = lat_set | (lat_q & ~lat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      lthr_q <= '0;
    end else begin
      lat_q  <= lat_d;
      lthr_q <= lthr;
    end
  end

  always_comb begin
    status              = '0;
    status[NLAT-1:0]    = lat_q;
    status[B_NH]        = nh_flag;
    status[B_NL]        = nl_flag;
  end
endmodule

// File: rtl/thr_alarm_chk.sv
module thr_alarm_chk #(
  parameter int W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [W-1:0] sample,
  input logic [W-1:0] hh_thr,
  input logic [W-1:0] ll_thr,
  input logic [W-1:0] nl_hi_thr,
  input logic [W-1:0] nl_lo_thr,
  input logic        stat_wr,
  input logic [15:0] stat_wdata,
  input logic [15:0] status
);
  // R11
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:5] == 3'b0) && (status[15:10] == 6'b0));

  // R3
  hh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> ($past(stat_wr && !stat_wdata[0]) || ($past(hh_thr) != $past(hh_thr, 2))));

  // R7
  nh_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[8]) |-> ($past(tick) && ($past(nl_hi_thr) != '0) && ($past(sample) >= $past(nl_hi_thr))));

  // R8
  nl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[9]) |-> (($past(sample) > $past(nl_lo_thr)) || ($past(nl_lo_thr) == '0)));

  // R9
  hh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hh_thr) == '0) |-> !status[0]);

  // R10
  off_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> ($past(tick) && ($past(ll_thr) != '0) && ($past(sample) <= $past(ll_thr))));
endmodule

bind thr_alarm_eng thr_alarm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .hh_thr(hh_thr),
  .ll_thr(ll_thr), .nl_hi_thr(nl_hi_thr), .nl_lo_thr(nl_lo_thr),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .status(status)
);

// File: tb/sim_thr_alarm_eng.sv
module sim_thr_alarm_eng;
  localparam int W = 12;
  localparam int DW = 4;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0;
  logic rst_n, tick, stat_wr;
  logic [W-1:0] sample, hh_thr, hi_thr, lo_thr, ll_thr, nl_hi_thr, nl_lo_thr;
  logic [6:0] hyst_pct;
  logic [DW-1:0] hh_dly, hi_dly, lo_dly, ll_dly, on_dly, off_dly;
  logic [15:0] stat_wdata, status;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int m_cnt[4];
  int m_prev[4];
  int m_on_cnt, m_off_cnt;
  bit m_on;
  bit [4:0] m_lat;
  bit m_nh, m_nl;

  always #(CLK_PER/2) clk = ~clk;

  thr_alarm_eng #(.W(W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample),
    .hh_thr(hh_thr), .hi_thr(hi_thr), .lo_thr(lo_thr), .ll_thr(ll_thr),
    .nl_hi_thr(nl_hi_thr), .nl_lo_thr(nl_lo_thr), .hyst_pct(hyst_pct),
    .hh_dly(hh_dly), .hi_dly(hi_dly), .lo_dly(lo_dly), .ll_dly(ll_dly),
    .on_dly(on_dly), .off_dly(off_dly), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .status(status)
  );

  function automatic int thr_of(int k);
    case (k)
      0: return int'(hh_thr);
      1: return int'(hi_thr);
      2: return int'(lo_thr);
      default: return int'(ll_thr);
    endcase
  endfunction

  function automatic int dly_of(int k);
    case (k)
      0: return int'(hh_dly);
      1: return int'(hi_dly);
      2: return int'(lo_dly);
      default: return int'(ll_dly);
    endcase
  endfunction

  function automatic bit [15:0] m_status();
    bit [15:0] s = '0;
    s[4:0] = m_lat;
    s[8] = m_nh;
    s[9] = m_nl;
    return s;
  endfunction

  // Advance the model by one clock edge using the driven inputs (R2..R10).
  task automatic model_edge();
    int s = int'(sample);
    int h = (hyst_pct > 100) ? 100 : int'(hyst_pct);
    bit [4:0] setv = '0, clrv = '0;
    bit on_hit, off_hit, en_ll;
    for (int k = 0; k < 4; k++) begin
      int t = thr_of(k);
      bit c = (t != 0) && ((k < 2) ? (s >= t) : (s <= t));
      if (tick && c && m_cnt[k] >= dly_of(k)) setv[k] = 1;
      if (t != m_prev[k]) clrv[k] = 1;
      if (tick) m_cnt[k] = !c ? 0 : ((m_cnt[k] < dly_of(k)) ? m_cnt[k] + 1 : m_cnt[k]);
    end
    if (int'(ll_thr) != m_prev[3]) clrv[4] = 1;
    en_ll = (ll_thr != 0);
    begin
      bit oc = en_ll && !m_on && (s > int'(ll_thr));
      bit fc = en_ll && m_on && !(s > int'(ll_thr));
      on_hit  = tick && oc && (m_on_cnt >= int'(on_dly));
      off_hit = tick && fc && (m_off_cnt >= int'(off_dly));
      if (tick) begin
        m_on_cnt  = !oc ? 0 : ((m_on_cnt < int'(on_dly)) ? m_on_cnt + 1 : m_on_cnt);
        m_off_cnt = !fc ? 0 : ((m_off_cnt < int'(off_dly)) ? m_off_cnt + 1 : m_off_cnt);
      end
      if (!en_ll) m_on = 0;
      else if (on_hit) m_on = 1;
      else if (off_hit) m_on = 0;
    end
    setv[4] = off_hit;
    if (stat_wr) clrv = clrv | ~stat_wdata[4:0];
    m_lat = setv | (m_lat & ~clrv);
    // non-latching with hysteresis
    if (nl_hi_thr == 0) m_nh = 0;
    else if (tick) begin
      int rel = int'(nl_hi_thr) * (100 - h) / 100;
      if (!m_nh && s >= int'(nl_hi_thr)) m_nh = 1;
      else if (m_nh && s < rel) m_nh = 0;
    end
    if (nl_lo_thr == 0) m_nl = 0;
    else if (tick) begin
      int rel = int'(nl_lo_thr) * (100 + h) / 100;
      if (!m_nl && s <= int'(nl_lo_thr)) m_nl = 1;
      else if (m_nl && s > rel) m_nl = 0;
    end
    for (int k = 0; k < 4; k++) m_prev[k] = thr_of(k);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bit actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: inputs already driven at negedge; compare after next negedge.
  task automatic cyc(string req, bit tk, bit wr = 0, logic [15:0] wd = 16'hFFFF);
    tick = tk; stat_wr = wr; stat_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    tick = 0; stat_wr = 0;
    check(req, status, m_status());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4711);
    rst_n = 0; tick = 0; stat_wr = 0; stat_wdata = '0;
    sample = 12'd1500; hh_thr = 12'd3000; hi_thr = 12'd2500; lo_thr = 12'd1000;
    ll_thr = 12'd500; nl_hi_thr = 12'd2800; nl_lo_thr = 12'd800; hyst_pct = 7'd10;
    hh_dly = 4'd3; hi_dly = 4'd2; lo_dly = 4'd2; ll_dly = 4'd2; on_dly = 4'd1; off_dly = 4'd2;
    for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_prev[k] = 0; end
    m_on_cnt = 0; m_off_cnt = 0; m_on = 0; m_lat = '0; m_nh = 0; m_nl = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", status, 16'h0000);
    rst_n = 1;
    cyc("R1 idle", 0);

    // R2 / R7: high-high delay 3 needs 4 ticks; non-latching high immediate
    sample = 12'd3100;
    cyc("R7 nh immediate", 1);
    check_bit("R7 bit8 after 1 tick", status[8], 1'b1);
    cyc("R2 tick2", 1);
    cyc("R2 tick3", 1);
    check_bit("R2 hh not yet after 3 ticks", status[0], 1'b0);
    cyc("R2 tick4", 1);
    check_bit("R2 hh set on 4th tick", status[0], 1'b1);

    // R3 latching holds; R8 nh releases below 2520
    sample = 12'd1500;
    cyc("R3 hold", 1);
    cyc("R3 hold2", 1);
    check_bit("R3 hh still set", status[0], 1'b1);
    check_bit("R8 nh released", status[8], 1'b0);

    // R8 hysteresis hold band
    sample = 12'd2850; cyc("R8 nh set", 1);
    sample = 12'd2600; cyc("R8 in band", 1);
    check_bit("R8 nh holds in band", status[8], 1'b1);
    sample = 12'd2520; cyc("R8 at release point", 1);
    check_bit("R8 nh holds at release point", status[8], 1'b1);
    sample = 12'd2519; cyc("R8 below release", 1);
    check_bit("R8 nh clears below release", status[8], 1'b0);

    // R4 software clear only where data bit is 0, bits 8/9 untouched
    sample = 12'd2900; cyc("R4 nh set", 1);
    sample = 12'd1500;
    cyc("R4 clear bit0", 0, 1, 16'hFFFE);
    check_bit("R4 hh cleared", status[0], 1'b0);
    check_bit("R4 hi kept", status[1], 1'b1);
    cyc("R4 write zeros", 0, 1, 16'h0000);
    check_bit("R4 nh unaffected by write", status[8], 1'b1);
    check_bit("R4 hi cleared by zero", status[1], 1'b0);

    // R5 limit rewrite clears its level
    sample = 12'd3100;
    repeat (4) cyc("R5 arm", 1);
    check_bit("R5 hi set", status[1], 1'b1);
    hi_thr = 12'd2400;
    sample = 12'd1500;
    cyc("R5 thr change", 0);
    check_bit("R5 hi cleared by rewrite", status[1], 1'b0);
    check_bit("R5 hh kept", status[0], 1'b1);

    // R6 set beats clear
    sample = 12'd3100;
    repeat (4) cyc("R6 arm", 1);
    cyc("R6 collide", 1, 1, 16'h0000);
    check_bit("R6 hh set wins", status[0], 1'b1);

    // R9 zero limit disables
    hh_thr = 12'd0; sample = 12'd4000;
    repeat (6) cyc("R9 disabled", 1);
    check_bit("R9 hh never sets", status[0], 1'b0);
    hh_thr = 12'd3000;

    // R10 on/off detector
    cyc("R10 clr", 0, 1, 16'h0000);
    sample = 12'd600;
    repeat (2) cyc("R10 on", 1);
    sample = 12'd400;
    cyc("R10 off1", 1); cyc("R10 off2", 1);
    check_bit("R10 off not yet", status[4], 1'b0);
    cyc("R10 off3", 1);
    check_bit("R10 off latched", status[4], 1'b1);
    check_bit("R2 ll latched", status[3], 1'b1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) begin
        case ($urandom_range(0, 5))
          0: hh_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(2800, 3400));
          1: hi_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(2200, 2800));
          2: lo_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(900, 1300));
          3: ll_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(300, 700));
          4: nl_hi_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(2400, 3000));
          default: nl_lo_thr = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(600, 1100));
        endcase
      end
      if (r > 96) begin
        hyst_pct = 7'($urandom_range(0, 127));
        hh_dly = 4'($urandom_range(0, 15)); hi_dly = 4'($urandom_range(0, 15));
        lo_dly = 4'($urandom_range(0, 15)); ll_dly = 4'($urandom_range(0, 15));
        on_dly = 4'($urandom_range(0, 15)); off_dly = 4'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 9) < 3) begin
        case ($urandom_range(0, 3))
          0: sample = 12'($urandom_range(0, 4095));
          1: sample = 12'($urandom_range(2200, 3500));
          2: sample = 12'($urandom_range(200, 1300));
          default: sample = nl_hi_thr;
        endcase
      end
      cyc("R2-R10 random", $urandom_range(0, 1) == 1, $urandom_range(0, 19) == 0,
          16'($urandom_range(0, 65535)));
      check("R11 reserved zero", status & 16'hFCE0, 16'h0000);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule